// File: doc/BRIEF.md
# Cache Line Lock Controller

This block keeps one lock bit for every way of every set of a 4-way, 64-set cache level. It also holds that level's tag and valid bits and a three-bit tree pseudo-LRU state for each set. Commands arrive on a valid/ready port. Each command carries an operation code, a cache-target field and a byte address. Only commands whose target field equals the level number `LEVEL_ID` (default 0) take effect. Every other target value, valid or not, is a no-op.

A lock-set command that hits locks the resident line. A lock-set command that misses requests a line fill, then writes the line in valid and locked when the fill acknowledge arrives. A lock-clear command that hits releases the line. A plain touch command allocates without locking. Victim selection never picks a locked way. A set whose four ways are all locked refuses allocation and raises a flag.

The controller is a two-state machine:
- `ST_IDLE`: accepts commands, with `cmd_ready` high.
- `ST_FILL`: holds one outstanding fill request, with `cmd_ready` low.

The transitions are:
- `ST_IDLE` → `ST_FILL`: an accepted touch or lock-set misses in a set that is not fully locked.
- `ST_FILL` → `ST_IDLE`: `fill_ack` is sampled high.
- All other cases: the state holds.

Top module: `line_lock_ctl`

## Requirements
- R1: A command takes effect only when `cmd_ct` equals `LEVEL_ID` (0 by default). With any other target value (1, 2 or 3) the command is accepted but changes no lock, valid, tag or replacement state, raises no fill request and no overflow pulse.
- R2: A lock-set command (`cmd_op` = 1) that hits a valid line sets that line's lock bit and updates the replacement state for that way. It raises no fill request.
- R3: A lock-set command that misses in a set with at least one unlocked way raises `fill_req` in the cycle after acceptance. `fill_addr` is the command address with its 4 offset bits zeroed, and `fill_way` is the victim shown at acceptance. When `fill_ack` is sampled, that way becomes valid with the new tag and locked.
- R4: A lock-clear command (`cmd_op` = 2) that hits clears that line's lock bit. One that misses changes nothing.
- R5: `victim_way` is combinational for the set indexed by `cmd_addr[9:4]` and is never a locked way. It is chosen by a three-bit pseudo-LRU state p per set, reset to 0, as follows:
  - Side selection: go to ways 2/3 if ways 0 and 1 are both locked, go to ways 0/1 if ways 2 and 3 are both locked, otherwise go to ways 2/3 when p[0]=1.
  - Way within a pair: take the unlocked way if exactly one is locked, otherwise take the upper way when p[1] (for ways 0/1) or p[2] (for ways 2/3) is 1.
  - Update on an access to way w (a touch or lock-set hit, or a fill completion): p[0] ← ~w[1], and then either p[1] ← ~w[0] when w[1]=0, or p[2] ← ~w[0] when w[1]=1.
- R6: `all_locked` is high exactly when all four ways of the indexed set are locked. A touch or lock-set miss in such a set raises no fill.
- R7: A lock-set miss in a fully locked set pulses `lock_ovf` for exactly the one cycle after acceptance.
- R8: At most one fill is outstanding. `cmd_ready` is low, and `fill_req` high, from the cycle after a filling command is accepted until `fill_ack` is sampled. Both return (ready high, request low) in the following cycle.
- R9: `flash_clr` clears every lock bit at the next clock edge. It takes priority over a lock set at the same edge.
- R10: Reset clears all valid and lock bits and the replacement state. After reset every lookup misses, `victim_way` is 0 and `all_locked` is 0.
- R11: A touch command (`cmd_op` = 0) that hits only updates the replacement state. One that misses fills the victim way as for R3, but leaves the line unlocked.
- R12: Operation code 3 is a no-op, whatever the other command fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flash_clr | input | 1 | Clear all lock bits |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 0 touch, 1 lock-set, 2 lock-clear, 3 no-op |
| cmd_ct | input | CT_W | Cache-target level |
| cmd_addr | input | ADDR_W | Byte address of command |
| fill_req | output | 1 | Line fill request outstanding |
| fill_ack | input | 1 | Fill completed |
| fill_addr | output | ADDR_W | Line-aligned fill address |
| fill_way | output | 2 | Way being filled |
| victim_way | output | 2 | Victim way for the indexed set |
| all_locked | output | 1 | All ways of the indexed set are locked |
| lock_ovf | output | 1 | Lock-set refused, set fully locked |

## Verification
`victim_way` and `all_locked` follow `cmd_addr` in the same cycle, so the bench compares them a short delay after it drives the address. Effects of a hit become visible in those outputs from the cycle after the accepting edge. `fill_req`, `fill_addr`, `fill_way`, `lock_ovf` and the drop of `cmd_ready` are due one cycle after the accepting edge. A fill completion shows `cmd_ready` high again one cycle after the edge that samples `fill_ack`. Inputs are driven and outputs sampled only on falling edges, so every check lands in the exact cycle listed above.

// File: rtl/lock_ctl_pkg.sv
package lock_ctl_pkg;
    typedef enum logic [1:0] {
        OP_TOUCH  = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_NOP    = 2'd3
    } lk_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } lk_state_e;

    localparam int PLRU_W = 3;

    function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] p, input logic [1:0] w);
        logic [PLRU_W-1:0] n;
        n    = p;
        n[0] = ~w[1];
        if (!w[1]) n[1] = ~w[0];
        else       n[2] = ~w[0];
        return n;
    endfunction
endpackage

// File: rtl/lock_tag_match.sv
module lock_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int WAY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            valid_row,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
    input  logic [TAG_W-1:0]           tag_in,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valid_row[g] && (tag_row[g] == tag_in);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/lock_victim_sel.sv
module lock_victim_sel
    import lock_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        lock_row,
    input  logic [PLRU_W-1:0] plru_row,
    output logic [1:0]        victim,
    output logic              all_locked
);
    logic lo_full, hi_full, go_hi;

    always_comb begin
        lo_full    = lock_row[0] & lock_row[1];
        hi_full    = lock_row[2] & lock_row[3];
        all_locked = lo_full & hi_full;
        if (hi_full)      go_hi = 1'b0;
        else if (lo_full) go_hi = 1'b1;
        else              go_hi = plru_row[0];
        if (go_hi) begin
            if (lock_row[2])      victim = 2'd3;
            else if (lock_row[3]) victim = 2'd2;
            else                  victim = plru_row[2] ? 2'd3 : 2'd2;
        end else begin
            if (lock_row[0])      victim = 2'd1;
            else if (lock_row[1]) victim = 2'd0;
            else                  victim = plru_row[1] ? 2'd1 : 2'd0;
        end
    end

    // R5
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !all_locked |-> !lock_row[victim]);
endmodule

// File: rtl/line_lock_ctl.sv
module line_lock_ctl
    import lock_ctl_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int OFF_W    = 4,
    parameter int IDX_W    = 6,
    parameter int CT_W     = 2,
    parameter int LEVEL_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_clr,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [CT_W-1:0]   cmd_ct,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              fill_req,
    input  logic              fill_ack,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [1:0]        fill_way,
    output logic [1:0]        victim_way,
    output logic              all_locked,
    output logic              lock_ovf
);
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            lock_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [PLRU_W-1:0]          plru_q  [SETS];

    lk_state_e         state_q, state_d;
    logic [LINE_W-1:0] fill_line_q;
    logic [WAY_W-1:0]  fill_way_q;
    logic              fill_lock_q;
    logic              ovf_q;

    lk_op_e            op;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  vict;
    logic              full;
    logic              act, wants_line, start_fill;
    logic [IDX_W-1:0]  f_idx;
    logic [TAG_W-1:0]  f_tag;
    logic              unused_off;

    assign op         = lk_op_e'(cmd_op);
    assign cur_idx    = cmd_addr[OFF_W +: IDX_W];
    assign cur_tag    = cmd_addr[ADDR_W-1 -: TAG_W];
    assign unused_off = ^cmd_addr[OFF_W-1:0];
    assign f_idx      = fill_line_q[IDX_W-1:0];
    assign f_tag      = fill_line_q[LINE_W-1 -: TAG_W];

    lock_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) match_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_row (valid_q[cur_idx]),
        .tag_row   (tag_q[cur_idx]),
        .tag_in    (cur_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    lock_victim_sel vsel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_row   (lock_q[cur_idx]),
        .plru_row   (plru_q[cur_idx]),
        .victim     (vict),
        .all_locked (full)
    );

    assign act        = cmd_valid && cmd_ready && (cmd_ct == CT_W'(LEVEL_ID)) && (op != OP_NOP);
    assign wants_line = (op == OP_TOUCH) || (op == OP_LOCK);
    assign start_fill = act && wants_line && !hit && !full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_fill) state_d = ST_FILL;
            ST_FILL: if (fill_ack)   state_d = ST_IDLE;
        endcase
    end

    // Outputs and per-set state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
                tag_q[s]   <= '0;
                plru_q[s]  <= '0;
            end
            fill_line_q <= '0;
            fill_way_q  <= '0;
            fill_lock_q <= 1'b0;
            ovf_q       <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (act) begin
                unique case (op)
                    OP_TOUCH: if (hit) plru_q[cur_idx] <= plru_touch(plru_q[cur_idx], hit_way);
                    OP_LOCK: begin
                        if (hit) begin
                            lock_q[cur_idx][hit_way] <= 1'b1;
                            plru_q[cur_idx]          <= plru_touch(plru_q[cur_idx], hit_way);
                        end else if (full) begin
                            ovf_q <= 1'b1;
                        end
                    end
                    OP_UNLOCK: if (hit) lock_q[cur_idx][hit_way] <= 1'b0;
                    default: ;
                endcase
            end
            if (start_fill) begin
                fill_line_q <= cmd_addr[ADDR_W-1:OFF_W];
                fill_way_q  <= vict;
                fill_lock_q <= (op == OP_LOCK);
            end
            if (state_q == ST_FILL && fill_ack) begin
                valid_q[f_idx][fill_way_q] <= 1'b1;
                tag_q[f_idx][fill_way_q]   <= f_tag;
                lock_q[f_idx][fill_way_q]  <= fill_lock_q;
                plru_q[f_idx]              <= plru_touch(plru_q[f_idx], fill_way_q);
            end
            if (flash_clr) begin
                for (int s = 0; s < SETS; s++) lock_q[s] <= '0;
            end
        end
    end

    assign cmd_ready  = (state_q == ST_IDLE);
    assign fill_req   = (state_q == ST_FILL);
    assign fill_addr  = {fill_line_q, {OFF_W{1'b0}}};
    assign fill_way   = fill_way_q;
    assign victim_way = vict;
    assign all_locked = full;
    assign lock_ovf   = ovf_q;

    // R8
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_ack |=> fill_req && !cmd_ready);
    // R8
    fill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && fill_ack |=> cmd_ready && !fill_req);
    // R9
    flash_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_clr |=> !all_locked);
    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ovf |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd1 && cmd_ct == CT_W'(LEVEL_ID)));
    // R1
    fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> $past(cmd_valid && cmd_ct == CT_W'(LEVEL_ID) && cmd_op != 2'd3));
endmodule

// File: tb/line_lock_ctl_tb_top.sv
`timescale 1ns/1ps
module line_lock_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_clr = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_ct = 2'd0;
    logic [15:0] cmd_addr = 16'h0;
    logic        fill_req;
    logic        fill_ack = 1'b0;
    logic [15:0] fill_addr;
    logic [1:0]  fill_way;
    logic [1:0]  victim_way;
    logic        all_locked;
    logic        lock_ovf;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // bench model
    logic [3:0] m_valid [64];
    logic [3:0] m_lock  [64];
    logic [5:0] m_tag   [64][4];
    logic [2:0] m_plru  [64];

    always #5 clk = ~clk;

    line_lock_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .flash_clr(flash_clr),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_ct(cmd_ct), .cmd_addr(cmd_addr), .fill_req(fill_req),
        .fill_ack(fill_ack), .fill_addr(fill_addr), .fill_way(fill_way),
        .victim_way(victim_way), .all_locked(all_locked), .lock_ovf(lock_ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] m_victim(input logic [3:0] lk, input logic [2:0] p);
        logic hi;
        if (lk[2] && lk[3])      hi = 1'b0;
        else if (lk[0] && lk[1]) hi = 1'b1;
        else                     hi = p[0];
        if (hi) return lk[2] ? 2'd3 : lk[3] ? 2'd2 : (p[2] ? 2'd3 : 2'd2);
        return lk[0] ? 2'd1 : lk[1] ? 2'd0 : (p[1] ? 2'd1 : 2'd0);
    endfunction

    function automatic logic [2:0] m_upd(input logic [2:0] p, input logic [1:0] w);
        logic [2:0] r = p;
        r[0] = !w[1];
        if (w[1]) r[2] = !w[0];
        else      r[1] = !w[0];
        return r;
    endfunction

    function automatic logic [15:0] mk(input int t, input int i);
        return {t[5:0], i[5:0], 4'h0};
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 64; s++) begin
            m_valid[s] = 4'h0; m_lock[s] = 4'h0; m_plru[s] = 3'h0;
            for (int w = 0; w < 4; w++) m_tag[s][w] = 6'h0;
        end
    endtask

    task automatic probe(input logic [15:0] addr, input string req);
        int s = int'(addr[9:4]);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr  = addr;
        #1;
        check({req, " all_locked"}, all_locked, &m_lock[s]);
        if (!(&m_lock[s])) check({req, " victim"}, victim_way, m_victim(m_lock[s], m_plru[s]));
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [1:0] ct, input logic [15:0] addr);
        int s = int'(addr[9:4]);
        logic [5:0] t = addr[15:10];
        logic hitm = 1'b0;
        logic [1:0] hw = 2'd0;
        logic [1:0] ev;
        logic ea, act, efill, eovf;
        string rq;
        @(negedge clk);
        cmd_op = op; cmd_ct = ct; cmd_addr = addr; cmd_valid = 1'b1;
        #1;
        for (int w = 3; w >= 0; w--) if (m_valid[s][w] && m_tag[s][w] == t) begin hitm = 1'b1; hw = 2'(w); end
        ev = m_victim(m_lock[s], m_plru[s]);
        ea = &m_lock[s];
        act = (ct == 2'd0) && (op != 2'd3);
        efill = act && !hitm && (op <= 2'd1) && !ea;
        eovf  = act && (op == 2'd1) && !hitm && ea;
        rq = (ct != 0) ? "R1" : (op == 3) ? "R12" : (op == 2) ? "R4" : (op == 0) ? "R11" :
             hitm ? "R2" : ea ? "R7" : "R3";
        check("R8 ready idle", cmd_ready, 1);
        check("R6 all_locked", all_locked, ea);
        if (!ea) check("R5 victim", victim_way, ev);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (act && hitm) begin
            if (op == 2'd1) begin m_lock[s][hw] = 1'b1; m_plru[s] = m_upd(m_plru[s], hw); end
            if (op == 2'd0) m_plru[s] = m_upd(m_plru[s], hw);
            if (op == 2'd2) m_lock[s][hw] = 1'b0;
        end
        check({rq, " fill_req"}, fill_req, efill);
        check("R7 lock_ovf", lock_ovf, eovf);
        check("R8 ready", cmd_ready, !efill);
        if (efill) begin
            int k = $urandom_range(0, 3);
            check("R3 fill_addr", fill_addr, {addr[15:4], 4'h0});
            check("R3 fill_way", fill_way, ev);
            for (int j = 0; j < k; j++) begin
                @(negedge clk);
                check("R8 fill held", {fill_req, cmd_ready}, 2'b10);
            end
            fill_ack = 1'b1;
            @(negedge clk);
            fill_ack = 1'b0;
            m_valid[s][ev] = 1'b1; m_tag[s][ev] = t;
            m_lock[s][ev] = (op == 2'd1);
            m_plru[s] = m_upd(m_plru[s], ev);
            check("R8 fill release", {fill_req, cmd_ready}, 2'b01);
        end
    endtask

    task automatic flash();
        @(negedge clk);
        flash_clr = 1'b1;
        @(negedge clk);
        flash_clr = 1'b0;
        for (int s = 0; s < 64; s++) m_lock[s] = 4'h0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 fill_req", fill_req, 0);
        check("R10 ready", cmd_ready, 1);
        check("R10 ovf", lock_ovf, 0);
        probe(mk(1, 5), "R10");
        check("R10 victim zero", victim_way, 0);

        // R3 fill four ways of set 5 with locks
        for (int t = 1; t <= 4; t++) do_cmd(2'd1, 2'd0, mk(t, 5));
        probe(mk(1, 5), "R6 full");
        check("R6 full set", all_locked, 1);
        do_cmd(2'd0, 2'd0, mk(5, 5));          // R6 touch miss refused
        do_cmd(2'd1, 2'd0, mk(5, 5) | 16'h7);  // R7 overflow
        do_cmd(2'd1, 2'd0, mk(2, 5));          // R2 hit
        do_cmd(2'd2, 2'd0, mk(3, 5));          // R4 hit clear
        probe(mk(3, 5), "R4 released");
        do_cmd(2'd2, 2'd0, mk(9, 5));          // R4 miss
        do_cmd(2'd1, 2'd1, mk(7, 9));          // R1 other level
        do_cmd(2'd1, 2'd2, mk(7, 9));          // R1 invalid level
        do_cmd(2'd1, 2'd3, mk(7, 9));          // R1 invalid level
        do_cmd(2'd3, 2'd0, mk(7, 9));          // R12
        probe(mk(7, 9), "R1 untouched");
        do_cmd(2'd0, 2'd0, mk(6, 5));          // R11 touch miss
        probe(mk(6, 5), "R11 unlocked");
        do_cmd(2'd0, 2'd0, mk(6, 5));          // R11 touch hit
        flash();
        probe(mk(1, 5), "R9 flash");

        // R9 flash together with lock-set hit: flash wins
        do_cmd(2'd1, 2'd0, mk(1, 5));
        do_cmd(2'd1, 2'd0, mk(2, 5));
        do_cmd(2'd1, 2'd0, mk(4, 5));
        @(negedge clk);
        cmd_op = 2'd1; cmd_ct = 2'd0; cmd_addr = mk(6, 5); cmd_valid = 1'b1; flash_clr = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; flash_clr = 1'b0;
        for (int s = 0; s < 64; s++) m_lock[s] = 4'h0;
        for (int w = 0; w < 4; w++) if (m_valid[5][w] && m_tag[5][w] == 6'd6) m_plru[5] = m_upd(m_plru[5], 2'(w));
        probe(mk(6, 5), "R9 priority");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom_range(0, 2);
            int idx = (sel == 0) ? 0 : (sel == 1) ? 5 : 63;
            logic [1:0] op = 2'($urandom_range(0, 3));
            logic [1:0] ct = ($urandom_range(0, 7) < 6) ? 2'd0 : 2'($urandom_range(0, 3));
            logic [15:0] a = mk($urandom_range(0, 6), idx) | 16'($urandom_range(0, 15));
            if ($urandom_range(0, 39) == 0) flash();
            do_cmd(op, ct, a);
        end
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234));
    end
endmodule